// File: doc/BRIEF.md
# Bit-Sliced Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit for a processor datapath. It is assembled from one identical single-bit cell repeated across the word. Each cell can invert either operand, forms the AND, the OR and a full-adder sum of the two, and picks one of four candidates for its result bit. The carry leaving each cell enters the next one, so the adder ripples from the least significant bit upward. A small flag stage sits beside the top cell. It produces the signed overflow indication and the signed less-than bit, and that bit is routed back to the lowest cell.

A 4-bit control word selects the operation. Bit 3 inverts operand A. Bit 2 inverts operand B and also serves as the carry into bit 0, which turns addition into two's-complement subtraction. Bits 1:0 choose the cell result: 0 = AND, 1 = OR, 2 = sum, 3 = less-than input. Equality is tested by subtracting and reading the zero flag.

Top module: `ripple_alu`

## Requirements
- R1: Control 4'b0000 gives result = a AND b.
- R2: Control 4'b0001 gives result = a OR b.
- R3: Control 4'b0010 gives result = (a + b) mod 2^32, and carry_out equals bit 32 of the unsigned sum.
- R4: Control 4'b0110 gives result = (a - b) mod 2^32, and carry_out is 1 exactly when a >= b as unsigned values (no borrow).
- R5: Control 4'b0111 gives result = 1 when a < b as signed two's-complement values and 0 otherwise, with bits 31:1 always 0. This holds even when a - b overflows.
- R6: Control 4'b1100 gives result = NOT (a OR b).
- R7: zero is 1 exactly when all 32 result bits are 0.
- R8: For controls 4'b0010, 4'b0110 and 4'b0111, overflow is 1 exactly when the signed result of a + b (or a - b) does not fit in 32 bits.
- R9: Every other control value (the ten codes not listed in R1 to R6) gives result = 0, and zero = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| ctrl | input | 4 | {invert A, negate B, select[1:0]} |
| result | output | 32 | Selected result word |
| zero | output | 1 | High when result is all zeros |
| overflow | output | 1 | Signed overflow of the add/subtract path |
| carry_out | output | 1 | Carry out of the top cell |

## Verification
All sixteen control codes are applied to every pair drawn from 0, 1, -1, the most positive and the most negative value. Those pairs separate the signed from the unsigned behaviour of subtract, carry and less-than, and they produce overflow in both directions, including the case where set-on-less-than must correct the raw sign bit. Random operand pairs under every code then catch a single wrong cell or a broken link in the carry chain, which the corner values alone can miss. The unused codes show whether anything other than zero leaks out of the decode.

// File: rtl/ralu_pkg.sv
package ralu_pkg;

    typedef enum logic [1:0] {
        SEL_AND  = 2'd0,
        SEL_OR   = 2'd1,
        SEL_SUM  = 2'd2,
        SEL_LESS = 2'd3
    } sel_e;

    typedef struct packed {
        logic inv_a;
        logic neg_b;
        sel_e sel;
    } ctrl_t;

    // True for the six supported control codes
    function automatic logic ctrl_supported(input logic [3:0] code);
        case (code)
            4'b0000, 4'b0001, 4'b0010,
            4'b0110, 4'b0111, 4'b1100: return 1'b1;
            default:                   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import ralu_pkg::*;
(
    input  logic a,
    input  logic b,
    input  logic inv_a,
    input  logic neg_b,
    input  logic carry_in,
    input  logic less,
    input  sel_e sel,
    output logic sum,
    output logic result,
    output logic carry_out
);

    logic a_eff;
    logic b_eff;

    always_comb begin
        a_eff     = a ^ inv_a;
        b_eff     = b ^ neg_b;
        sum       = a_eff ^ b_eff ^ carry_in;
        carry_out = (a_eff & b_eff) | (a_eff & carry_in) | (b_eff & carry_in);
    end

    always_comb begin
        unique case (sel)
            SEL_AND:  result = a_eff & b_eff;
            SEL_OR:   result = a_eff | b_eff;
            SEL_SUM:  result = sum;
            SEL_LESS: result = less;
            default:  result = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_msb_flags.sv
module alu_msb_flags (
    input  logic carry_into_msb,
    input  logic carry_out_msb,
    input  logic sum_msb,
    output logic overflow,
    output logic set_less
);

    always_comb begin
        overflow = carry_into_msb ^ carry_out_msb;
        // Sign of the true difference, corrected for overflow
        set_less = sum_msb ^ overflow;
    end

endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] value,
    output logic             is_zero
);

    always_comb is_zero = ~|value;

endmodule

// File: rtl/ripple_alu.sv
module ripple_alu
    import ralu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [3:0]       ctrl,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             overflow,
    output logic             carry_out
);

    localparam int MSB = WIDTH - 1;

    ctrl_t            ctl;
    logic             code_ok;
    logic [WIDTH:0]   chain;
    logic [WIDTH-1:0] sums;
    logic [WIDTH-1:0] raw;
    logic             set_less;

    always_comb begin
        ctl      = ctrl_t'(ctrl);
        code_ok  = ctrl_supported(ctrl);
        chain[0] = ctl.neg_b;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        logic less_in;
        if (i == 0) begin : g_lsb
            always_comb less_in = set_less;
        end else begin : g_upper
            always_comb less_in = 1'b0;
        end

        alu_bit_slice u_slice (
            .a         (op_a[i]),
            .b         (op_b[i]),
            .inv_a     (ctl.inv_a),
            .neg_b     (ctl.neg_b),
            .carry_in  (chain[i]),
            .less      (less_in),
            .sel       (ctl.sel),
            .sum       (sums[i]),
            .result    (raw[i]),
            .carry_out (chain[i+1])
        );
    end

    alu_msb_flags u_flags (
        .carry_into_msb (chain[MSB]),
        .carry_out_msb  (chain[WIDTH]),
        .sum_msb        (sums[MSB]),
        .overflow       (overflow),
        .set_less       (set_less)
    );

    always_comb begin
        result    = code_ok ? raw : '0;
        carry_out = chain[WIDTH];
    end

    alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
        .value   (result),
        .is_zero (zero)
    );

    always_comb begin
        if (ctrl == 4'b0010) begin
            assert_add_sum_R3: assert ({carry_out, result} == ({1'b0, op_a} + {1'b0, op_b}))
                else $error("ripple sum disagrees with arithmetic add");
        end
        if (ctrl == 4'b0110) begin
            assert_sub_diff_R4: assert (result == op_a - op_b)
                else $error("ripple difference disagrees with subtract");
        end
        if (ctrl == 4'b0111) begin
            assert_slt_bit_R5: assert (result == {{(WIDTH-1){1'b0}}, ($signed(op_a) < $signed(op_b))})
                else $error("set-on-less-than wrong");
        end
        if (ctrl == 4'b0010) begin
            assert_add_ovf_R8: assert (overflow == ((op_a[MSB] == op_b[MSB]) && (result[MSB] != op_a[MSB])))
                else $error("overflow flag wrong on add");
        end
        if (!ctrl_supported(ctrl)) begin
            assert_unused_zero_R9: assert (zero && result == '0)
                else $error("unused code leaked a result");
        end
    end

endmodule

// File: tb/test_ripple_alu.sv
module test_ripple_alu;

    localparam int CLK_PERIOD = 10;
    localparam int W = 32;
    localparam int WATCHDOG = 150000;

    logic         clk = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [3:0]   ctrl = '0;
    logic [W-1:0] result;
    logic         zero;
    logic         overflow;
    logic         carry_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit driving_done = 1'b0;

    typedef struct packed {
        logic [3:0]   code;
        logic [W-1:0] res;
        logic         zf;
        logic         ovf;
        logic         cy;
        logic         flags_valid;
    } exp_t;

    exp_t sb_q[$];

    ripple_alu #(.WIDTH(W)) i_ripple_alu (
        .op_a      (op_a),
        .op_b      (op_b),
        .ctrl      (ctrl),
        .result    (result),
        .zero      (zero),
        .overflow  (overflow),
        .carry_out (carry_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic string req_of(input logic [3:0] code);
        case (code)
            4'b0000: return "R1";
            4'b0001: return "R2";
            4'b0010: return "R3";
            4'b0110: return "R4";
            4'b0111: return "R5";
            4'b1100: return "R6";
            default: return "R9";
        endcase
    endfunction

    function automatic exp_t model(input logic [W-1:0] a, input logic [W-1:0] b, input logic [3:0] code);
        exp_t e;
        logic [W:0] wide;
        e = '0;
        e.code = code;
        case (code)
            4'b0000: e.res = a & b;
            4'b0001: e.res = a | b;
            4'b0010: e.res = a + b;
            4'b0110: e.res = a - b;
            4'b0111: e.res = ($signed(a) < $signed(b)) ? 1 : 0;
            4'b1100: e.res = ~(a | b);
            default: e.res = '0;
        endcase
        e.zf = (e.res == '0);
        if (code == 4'b0010) begin
            wide = {1'b0, a} + {1'b0, b};
            e.cy = wide[W];
            e.ovf = (a[W-1] == b[W-1]) && (wide[W-1] != a[W-1]);
            e.flags_valid = 1'b1;
        end else if (code == 4'b0110 || code == 4'b0111) begin
            wide = {1'b0, a} - {1'b0, b};
            e.cy = (a >= b);
            e.ovf = (a[W-1] != b[W-1]) && (wide[W-1] != a[W-1]);
            e.flags_valid = 1'b1;
        end
        return e;
    endfunction

    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic [3:0] code);
        @(negedge clk);
        op_a = a;
        op_b = b;
        ctrl = code;
        sb_q.push_back(model(a, b, code));
    endtask

    // Monitor: compare at the rising edge, half a period after inputs change
    always @(posedge clk) begin
        exp_t e;
        if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            checks++;
            if (result !== e.res) begin
                errors++;
                $display("FAIL %s ctrl=%b result actual=%h expected=%h", req_of(e.code), e.code, result, e.res);
            end
            checks++;
            if (zero !== e.zf) begin
                errors++;
                $display("FAIL R7 ctrl=%b zero actual=%b expected=%b", e.code, zero, e.zf);
            end
            if (e.flags_valid) begin
                checks++;
                if (overflow !== e.ovf) begin
                    errors++;
                    $display("FAIL R8 ctrl=%b overflow actual=%b expected=%b", e.code, overflow, e.ovf);
                end
                checks++;
                if (carry_out !== e.cy) begin
                    errors++;
                    $display("FAIL %s ctrl=%b carry_out actual=%b expected=%b", req_of(e.code), e.code, carry_out, e.cy);
                end
            end
        end
    end

    always @(posedge clk) cycles++;

    initial begin
        logic [W-1:0] corners [5];
        corners[0] = 32'h0000_0000;
        corners[1] = 32'h0000_0001;
        corners[2] = 32'hFFFF_FFFF;
        corners[3] = 32'h7FFF_FFFF;
        corners[4] = 32'h8000_0000;

        // Initial state: AND of zero operands, zero flag high (R1, R7)
        drive('0, '0, 4'b0000);

        // Corner pairs under all sixteen codes (R1..R9)
        for (int c = 0; c < 16; c++)
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 5; j++)
                    drive(corners[i], corners[j], 4'(c));

        // Equality through subtract (R4, R7)
        drive(32'h1234_5678, 32'h1234_5678, 4'b0110);
        // Overflowing less-than: most negative vs one (R5)
        drive(32'h8000_0000, 32'h0000_0001, 4'b0111);
        drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0111);

        // Random operands under every code (R1..R9)
        for (int n = 0; n < 300; n++)
            for (int c = 0; c < 16; c++)
                drive($urandom, $urandom, 4'(c));

        driving_done = 1'b1;
    end

    initial begin
        while (!(driving_done && sb_q.size() == 0) && cycles < WATCHDOG)
            @(negedge clk);
        if (cycles >= WATCHDOG) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule